// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Port with Pin-2 Function Selector

This block is a small four-pin port for a microcontroller-class core. It holds an output latch and a direction register, and it produces the drive value, output enable and weak pull-up enable for each pad. It brings the sampled pad levels back through a synchronizer as the port read value. Writing the latch has an effect whatever the pin direction is. Reading always returns the level on the pin, never the latch. Pin 3 can only be an input. Pin 2 has a three-level source selector: oscillator clock output first, then the timer clock input, then ordinary I/O.

The direction register has no data address. The core loads it with a dedicated strobe that carries the working-register value. A level input from the sleep controller marks the time spent in sleep. When sleep is entered the block takes a snapshot of the synchronized levels on the wake-capable pins. While sleep lasts, it raises a wake request as soon as one of those pins differs from the snapshot. When the clock output is on, pin 2 carries a one-cycle pulse for every fourth oscillator tick.

Top module: `gpio4_port`

## Requirements
- R1: After reset the direction register is 4'b1111 and the latch is 4'b0000. The pad outputs are then pad_oe = 0, pad_out = 0, pad_pu = 0 (with pu_n high), port_rd = 0 and wake_req = 0.
- R2: A cycle with dir_we high loads dir_wdata into the direction register at that edge. For pins 0 and 1, and for pin 2 when it is in I/O mode, a direction bit of 1 gives pad_oe = 0 (input) and a bit of 0 gives pad_oe = 1 (output).
- R3: A cycle with lat_we high loads lat_wdata into the latch at that edge, whatever the direction bits hold. pad_out[0], pad_out[1] and pad_out[3] always show the latch bits. pad_out[2] shows latch bit 2 whenever the clock output is off.
- R4: port_rd equals pad_in as sampled SYNC_STAGES clock edges earlier, whatever the direction and latch hold.
- R5: pad_oe[3] is always 0. Pin 3 never drives.
- R6: pad_pu[2] is always 0. pad_pu[3] equals !pu_n. pad_pu[0] and pad_pu[1] equal !pu_n ANDed with their direction bit, so a pull-up is on only for a pin that is an input.
- R7: Pin 2 follows this order of priority. With clkout_en high, pad_oe[2] = 1. Otherwise, with tmr_in_sel high, pad_oe[2] = 0. Otherwise pad_oe[2] follows the direction bit as in R2.
- R8: While clkout_en is high, an internal counter counts osc_tick cycles, starting from 0 when clkout_en goes high. pad_out[2] is 1 for the one cycle after every CLK_DIV-th counted tick, and 0 at all other times. While clkout_en is low the counter is held at 0.
- R9: A snapshot of the synchronized levels is taken at the first edge with sleeping high. From the next cycle on, while sleeping stays high, wake_req = !wake_n AND (any synchronized level on pins 0, 1 or 3 differs from the snapshot). A change on pin 2 never raises wake_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lat_we | input | 1 | Output latch write strobe |
| lat_wdata | input | 4 | Output latch write data |
| dir_we | input | 1 | Direction register load strobe |
| dir_wdata | input | 4 | Direction data from the working register (1 = input) |
| pu_n | input | 1 | Active-low weak pull-up enable |
| wake_n | input | 1 | Active-low wake-on-change enable |
| clkout_en | input | 1 | Clock-output enable for pin 2 |
| osc_tick | input | 1 | One-cycle strobe per oscillator pulse |
| tmr_in_sel | input | 1 | Pin 2 used as timer clock input |
| sleeping | input | 1 | Level from the sleep controller, high while asleep |
| pad_in | input | 4 | Raw pad levels |
| pad_out | output | 4 | Pad drive values |
| pad_oe | output | 4 | Pad output enables |
| pad_pu | output | 4 | Weak pull-up enables |
| port_rd | output | 4 | Synchronized port read value |
| wake_req | output | 1 | Wake-on-change request |

## Verification
The bench builds the port with SYNC_STAGES = 2 and CLK_DIV = 4. The short divider means the clock-output pulse comes around often, and random toggling of clkout_en cuts the tick count at every possible phase. With two synchronizer stages, a pad change reaches both the read value and the wake comparison within a few cycles of a random sleep entry. So changes that race the snapshot edge, and changes on pin 2 alone, each happen many times in one run.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;
  localparam logic [3:0] WAKE_PINS = 4'b1011;
  localparam logic [3:0] PULL_PINS = 4'b1011;

  typedef enum logic [1:0] {
    GP2_CLKOUT = 2'd0,
    GP2_TMRIN  = 2'd1,
    GP2_PLAIN  = 2'd2
  } gp2_src_e;

  function automatic gp2_src_e gp2_pick(input logic ck_en, input logic tsel);
    if (ck_en)     return GP2_CLKOUT;
    else if (tsel) return GP2_TMRIN;
    else           return GP2_PLAIN;
  endfunction

  function automatic logic [3:0] pull_vec(input logic pun, input logic [3:0] dir);
    if (pun) return 4'b0000;
    return (dir | 4'b1000) & PULL_PINS;
  endfunction

  function automatic logic wake_hit(input logic [3:0] now, input logic [3:0] snap);
    return |((now ^ snap) & WAKE_PINS);
  endfunction
endpackage

// File: rtl/gpio4_sync.sv
module gpio4_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] d,
  output logic [3:0] q
);
  logic [3:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio4_clkdiv.sv
module gpio4_clkdiv #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic pulse
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (tick) begin
      cnt   <= wrap ? '0 : cnt + 1'b1;
      pulse <= wrap;
    end else begin
      pulse <= 1'b0;
    end
  end

  AST_PULSE_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(en && tick)); // R8
endmodule

// File: rtl/gpio4_wake.sv
module gpio4_wake
  import gpio4_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleeping,
  input  logic       wake_n,
  input  logic [3:0] lvl,
  output logic       wake_req
);
  logic       armed;
  logic [3:0] snap;
  logic       diff_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      snap  <= '0;
    end else begin
      armed <= sleeping;
      if (sleeping && !armed) snap <= lvl;
    end
  end

  assign diff_seen = wake_hit(lvl, snap);
  assign wake_req  = armed && sleeping && !wake_n && diff_seen;

  AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ($past(sleeping) && !wake_n)); // R9
endmodule

// File: rtl/gpio4_port.sv
module gpio4_port
  import gpio4_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CLK_DIV     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lat_we,
  input  logic [3:0] lat_wdata,
  input  logic       dir_we,
  input  logic [3:0] dir_wdata,
  input  logic       pu_n,
  input  logic       wake_n,
  input  logic       clkout_en,
  input  logic       osc_tick,
  input  logic       tmr_in_sel,
  input  logic       sleeping,
  input  logic [3:0] pad_in,
  output logic [3:0] pad_out,
  output logic [3:0] pad_oe,
  output logic [3:0] pad_pu,
  output logic [3:0] port_rd,
  output logic       wake_req
);
  logic [3:0] dir_q;
  logic [3:0] lat_q;
  logic [3:0] lvl_sync;
  logic       ck_pulse;
  gp2_src_e   gp2_src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= 4'b1111;
      lat_q <= 4'b0000;
    end else begin
      if (dir_we) dir_q <= dir_wdata;
      if (lat_we) lat_q <= lat_wdata;
    end
  end

  gpio4_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(lvl_sync)
  );

  gpio4_clkdiv #(.DIV(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .en(clkout_en), .tick(osc_tick), .pulse(ck_pulse)
  );

  gpio4_wake u_wake (
    .clk(clk), .rst_n(rst_n), .sleeping(sleeping), .wake_n(wake_n),
    .lvl(lvl_sync), .wake_req(wake_req)
  );

  assign gp2_src = gp2_pick(clkout_en, tmr_in_sel);

  always_comb begin
    pad_out = lat_q;
    pad_oe  = {1'b0, 1'b0, ~dir_q[1], ~dir_q[0]};
    unique case (gp2_src)
      GP2_CLKOUT: begin pad_oe[2] = 1'b1; pad_out[2] = ck_pulse; end
      GP2_TMRIN:  pad_oe[2] = 1'b0;
      default:    pad_oe[2] = ~dir_q[2];
    endcase
  end

  assign pad_pu  = pull_vec(pu_n, dir_q);
  assign port_rd = lvl_sync;

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we |=> (dir_q == $past(dir_wdata))); // R2
  AST_LAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lat_we |=> (lat_q == $past(lat_wdata))); // R3
  AST_GP3_NEVER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe[3]); // R5
  AST_GP2_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_pu[2]); // R6
  AST_GP2_TMR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clkout_en && tmr_in_sel) |-> !pad_oe[2]); // R7
  AST_GP2_CLK_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    clkout_en |-> pad_oe[2]); // R7
endmodule

// File: tb/gpio4_port_test.sv
`timescale 1ns/1ps
module gpio4_port_test;
  localparam int TB_SYNC = 2;
  localparam int TB_DIV  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lat_we = 0, dir_we = 0, pu_n = 1, wake_n = 1;
  logic clkout_en = 0, osc_tick = 0, tmr_in_sel = 0, sleeping = 0;
  logic [3:0] lat_wdata = 0, dir_wdata = 0, pad_in = 0;
  logic [3:0] pad_out, pad_oe, pad_pu, port_rd;
  logic wake_req;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio4_port #(.SYNC_STAGES(TB_SYNC), .CLK_DIV(TB_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .lat_we(lat_we), .lat_wdata(lat_wdata),
    .dir_we(dir_we), .dir_wdata(dir_wdata), .pu_n(pu_n), .wake_n(wake_n),
    .clkout_en(clkout_en), .osc_tick(osc_tick), .tmr_in_sel(tmr_in_sel),
    .sleeping(sleeping), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .port_rd(port_rd), .wake_req(wake_req)
  );

  // Reference state, updated from the requirements at each rising edge
  logic [3:0] m_dir, m_lat, m_snap;
  logic [3:0] m_sh [TB_SYNC];
  int         m_cnt;
  logic       m_pulse, m_arm;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir <= 4'b1111; m_lat <= 4'b0000; m_snap <= 4'b0000;
      for (int k = 0; k < TB_SYNC; k++) m_sh[k] <= 4'b0000;
      m_cnt <= 0; m_pulse <= 1'b0; m_arm <= 1'b0;
    end else begin
      if (dir_we) m_dir <= dir_wdata;
      if (lat_we) m_lat <= lat_wdata;
      m_sh[0] <= pad_in;
      for (int k = 1; k < TB_SYNC; k++) m_sh[k] <= m_sh[k-1];
      if (!clkout_en) begin
        m_cnt <= 0; m_pulse <= 1'b0;
      end else if (osc_tick) begin
        m_pulse <= (m_cnt == TB_DIV - 1);
        m_cnt   <= (m_cnt + 1) % TB_DIV;
      end else begin
        m_pulse <= 1'b0;
      end
      m_arm <= sleeping;
      if (sleeping && !m_arm) m_snap <= m_sh[TB_SYNC-1];
    end
  end

  function automatic logic [3:0] exp_oe();
    logic g2;
    g2 = clkout_en ? 1'b1 : (tmr_in_sel ? 1'b0 : ~m_dir[2]);
    return {1'b0, g2, ~m_dir[1], ~m_dir[0]};
  endfunction

  function automatic logic [3:0] exp_pu();
    return pu_n ? 4'b0000 : {1'b1, 1'b0, m_dir[1], m_dir[0]};
  endfunction

  function automatic logic exp_wake();
    logic [3:0] d;
    d = (m_sh[TB_SYNC-1] ^ m_snap) & 4'b1011;
    return sleeping && m_arm && !wake_n && (d != 4'b0000);
  endfunction

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [3:0] eo;
    eo = exp_oe();
    chk("R2 pad_oe[1:0]", {2'b00, pad_oe[1:0]}, {2'b00, eo[1:0]});
    chk("R7 pad_oe[2]", {3'b000, pad_oe[2]}, {3'b000, eo[2]});
    chk("R5 pad_oe[3]", {3'b000, pad_oe[3]}, 4'b0000);
    chk("R3 pad_out latch bits", {pad_out[3], 1'b0, pad_out[1:0]}, {m_lat[3], 1'b0, m_lat[1:0]});
    if (clkout_en) chk("R8 pad_out[2] pulse", {3'b000, pad_out[2]}, {3'b000, m_pulse});
    else           chk("R3 pad_out[2] latch", {3'b000, pad_out[2]}, {3'b000, m_lat[2]});
    chk("R6 pad_pu", pad_pu, exp_pu());
    chk("R4 port_rd", port_rd, m_sh[TB_SYNC-1]);
    chk("R9 wake_req", {3'b000, wake_req}, {3'b000, exp_wake()});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    lat_we = 0; dir_we = 0; pu_n = 1; wake_n = 1; clkout_en = 0;
    osc_tick = 0; tmr_in_sel = 0; sleeping = 0; pad_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    do_reset();
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 4'b0000);
    chk("R1 pad_out", pad_out, 4'b0000);
    chk("R1 pad_pu", pad_pu, 4'b0000);
    chk("R1 port_rd", port_rd, 4'b0000);
    chk("R1 wake_req", {3'b000, wake_req}, 4'b0000);

    // R3 latch written while all pins are inputs, then pins turned to outputs
    lat_we = 1; lat_wdata = 4'b0111;
    @(negedge clk); lat_we = 0;
    chk("R3 oe still off", pad_oe, 4'b0000);
    dir_we = 1; dir_wdata = 4'b0000;
    @(negedge clk); dir_we = 0;
    chk("R3 latch shown", pad_out, 4'b0111);
    chk("R2 outputs on", pad_oe, 4'b0111);
    check_all();

    // R8 directed divider pattern with a tick every cycle
    clkout_en = 1; osc_tick = 1;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      chk("R8 directed pulse", {3'b000, pad_out[2]}, (c % TB_DIV == 0) ? 4'b0001 : 4'b0000);
    end
    clkout_en = 0; osc_tick = 0;
    @(negedge clk);

    // R9 directed: enter sleep, toggle pin 2 only, then pin 1
    wake_n = 0; pad_in = 4'b0000;
    repeat (3) @(negedge clk);
    sleeping = 1;
    repeat (2) begin @(negedge clk); check_all(); end
    pad_in = 4'b0100;
    repeat (4) begin @(negedge clk); check_all(); end
    chk("R9 pin2 no wake", {3'b000, wake_req}, 4'b0000);
    pad_in = 4'b0110;
    repeat (3) begin @(negedge clk); check_all(); end
    chk("R9 pin1 wakes", {3'b000, wake_req}, 4'b0001);
    sleeping = 0;
    @(negedge clk); check_all();

    // Constrained random
    for (int i = 0; i < 6000; i++) begin
      lat_we    = ($urandom % 6) == 0;
      lat_wdata = 4'($urandom);
      dir_we    = ($urandom % 6) == 0;
      dir_wdata = 4'($urandom);
      if (($urandom % 20) == 0) pu_n = ~pu_n;
      if (($urandom % 30) == 0) wake_n = ~wake_n;
      if (($urandom % 25) == 0) clkout_en = ~clkout_en;
      if (($urandom % 15) == 0) tmr_in_sel = ~tmr_in_sel;
      if (($urandom % 40) == 0) sleeping = ~sleeping;
      osc_tick = $urandom % 2;
      if (($urandom % 6) == 0) pad_in = pad_in ^ (4'b0001 << ($urandom % 4));
      if (i == 3000) do_reset();
      @(negedge clk);
      check_all();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule